// File: doc/BRIEF.md
# DRAM Start-up and Refresh Scheduler

This block tells an asynchronous DRAM controller when the memory may be used and when it must be refreshed. After reset it counts out a power-up settling time. It then holds a refresh request high until the controller has run a fixed number of warm-up refresh cycles. Only then does it raise a ready flag, which allows normal accesses to begin.

From that point on it raises one refresh request per row interval. The interval is short enough that every row is refreshed inside the retention period. The refresh is of the CAS-before-RAS kind, so no row address is passed to the controller. If the controller falls behind, the block keeps count of the intervals it still owes, up to a fixed limit. A sticky flag records any interval that was lost because the count was already at that limit.

Both times are given in nanoseconds together with the clock frequency. The cycle counts are worked out at elaboration: the start-up wait is rounded up and the refresh interval is rounded down.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ref_req`, `mem_ready` and `pend_overflow` are all low.
- R2: After reset is released, `ref_req` stays low for STARTUP_CYC rising edges and goes high on edge number STARTUP_CYC. STARTUP_CYC = ceil(STARTUP_NS·CLK_HZ/1e9), which is 10000 with the defaults.
- R3: `ref_ack` has no effect during the start-up wait. In the run phase it has no effect while nothing is owed: `ref_req` stays low and the next request still comes a full interval after the previous one.
- R4: In the warm-up phase, `ref_req` is held high without a break and `mem_ready` stays low. Each clock cycle in which `ref_ack` is high counts as one completed warm-up refresh.
- R5: `mem_ready` goes high on the clock edge that samples the WARMUP-th acknowledge (8 by default). It stays high until the next reset.
- R6: In the run phase, a refresh tick happens every INTERVAL_CYC cycles. The first tick comes INTERVAL_CYC edges after the edge that raised `mem_ready`. INTERVAL_CYC = floor(INTERVAL_NS·CLK_HZ/1e9), which is 781 with the defaults.
- R7: In the run phase there is an owed count, and `ref_req` is high exactly when that count is non-zero. A tick adds one to the count. An acknowledge taken while the count is non-zero removes one. When both happen on the same edge, the count does not change. An acknowledge seen while the count is zero is dropped, and any tick on that edge still adds one.
- R8: The owed count saturates at PEND_MAX (8). A tick that arrives while the count is at PEND_MAX, with no acknowledge on the same edge, sets `pend_overflow`. The flag stays set until reset, and PEND_MAX acknowledges then clear the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ack | input | 1 | High for one cycle per refresh the controller completes |
| ref_req | output | 1 | Refresh wanted |
| mem_ready | output | 1 | Warm-up done; normal accesses allowed |
| pend_overflow | output | 1 | Sticky: a refresh interval was lost at saturation |

## Verification
The bench checks the exact edge on which the start-up wait ends. A counter that is off by one there would show up as a request one cycle early or one cycle late. It gives acknowledges during the wait and while nothing is owed; a design that counted them would cut the warm-up short or let the owed count wrap below zero. It stops acknowledging for more than nine intervals to drive the count into saturation. A design that wrapped the count, or failed to latch the lost interval, would drop its request early after only a few acknowledges or leave the overflow flag low. It also checks that a reset in the middle of a run clears the ready flag and the overflow flag.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter longint CLK_HZ      = 50_000_000,
  parameter longint STARTUP_NS  = 200_000,
  parameter longint INTERVAL_NS = 15_625,
  parameter int     WARMUP      = 8,
  parameter int     PEND_MAX    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_req,
  output logic mem_ready,
  output logic pend_overflow
);

  localparam longint STARTUP_CYC  = (STARTUP_NS * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint INTERVAL_CYC = (INTERVAL_NS * CLK_HZ) / 64'd1_000_000_000;
  localparam longint CNT_TOP      = (STARTUP_CYC > INTERVAL_CYC) ? STARTUP_CYC : INTERVAL_CYC;
  localparam int     CW           = $clog2(CNT_TOP) + 1;
  localparam int     WW           = $clog2(WARMUP + 1);
  localparam int     PW           = $clog2(PEND_MAX + 1);
  localparam logic [CW-1:0] START_LAST = CW'(STARTUP_CYC - 1);
  localparam logic [CW-1:0] INTV_LAST  = CW'(INTERVAL_CYC - 1);
  localparam logic [PW-1:0] PMAX       = PW'(PEND_MAX);

  typedef enum logic [1:0] {PH_WAIT, PH_WARM, PH_RUN} phase_t;

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [WW-1:0]   warm_left;
  logic [PW-1:0]   pend, pend_nxt;
  logic            tick, ack_take;

  assign tick     = (phase == PH_RUN) && (cnt == INTV_LAST);
  assign ack_take = ref_ack && (pend != '0);

  always_comb begin
    pend_nxt = pend;
    case ({tick, ack_take})
      2'b10:   pend_nxt = (pend == PMAX) ? pend : pend + PW'(1);
      2'b01:   pend_nxt = pend - PW'(1);
      default: pend_nxt = pend;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_WAIT;
      cnt           <= '0;
      warm_left     <= WW'(WARMUP);
      pend          <= '0;
      mem_ready     <= 1'b0;
      pend_overflow <= 1'b0;
    end else begin
      case (phase)
        PH_WAIT: begin
          if (cnt == START_LAST) begin
            phase <= PH_WARM;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_WARM: begin
          if (ref_ack) begin
            warm_left <= warm_left - WW'(1);
            if (warm_left == WW'(1)) begin
              phase     <= PH_RUN;
              mem_ready <= 1'b1;
            end
          end
        end
        default: begin
          cnt  <= tick ? '0 : cnt + CW'(1);
          pend <= pend_nxt;
          if (tick && !ref_ack && pend == PMAX) pend_overflow <= 1'b1;
        end
      endcase
    end
  end

  assign ref_req = (phase == PH_WARM) || (pend != '0);

endmodule

// File: rtl/refsched_chk.sv
module refsched_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_ack,
  input logic ref_req,
  input logic mem_ready,
  input logic pend_overflow
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!ref_req && !mem_ready && !pend_overflow)); // R1

  AST_WARM_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !mem_ready) |=> (ref_req || mem_ready)); // R4

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) mem_ready |=> mem_ready); // R5

  AST_READY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_ready) |-> $past(ref_ack)); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) pend_overflow |=> pend_overflow); // R8

  AST_OVF_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(pend_overflow) |-> ref_req); // R8

endmodule

bind dram_refresh_sched refsched_chk u_refsched_chk (
  .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack),
  .ref_req(ref_req), .mem_ready(mem_ready), .pend_overflow(pend_overflow)
);

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;

  localparam int STARTUP  = 10000; // ceil(200000 ns * 50 MHz)
  localparam int INTERVAL = 781;   // floor(15625 ns * 50 MHz)
  localparam int WARM     = 8;
  localparam int PMAX     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ack = 1'b0;
  logic ref_req, mem_ready, pend_overflow;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int m_phase, m_cnt, m_warm, m_pend;
  bit m_ready, m_ovf;

  always #10 clk = ~clk;

  dram_refresh_sched dut (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack),
    .ref_req(ref_req), .mem_ready(mem_ready), .pend_overflow(pend_overflow)
  );

  function automatic bit exp_req();
    return (m_phase == 1) || (m_pend != 0);
  endfunction

  function automatic int next_pend(input int p, input bit tk, input bit a);
    bit take = a && (p != 0);
    if (tk && !take) return (p == PMAX) ? p : p + 1;
    if (!tk && take) return p - 1;
    return p;
  endfunction

  task automatic model_reset();
    m_phase = 0; m_cnt = 0; m_warm = WARM; m_pend = 0; m_ready = 0; m_ovf = 0;
  endtask

  task automatic model_edge(input bit a);
    bit tk;
    if (!rst_n) begin model_reset(); return; end
    case (m_phase)
      0: if (m_cnt == STARTUP - 1) begin m_phase = 1; m_cnt = 0; end else m_cnt++;
      1: if (a) begin
           m_warm--;
           if (m_warm == 0) begin m_phase = 2; m_ready = 1; end
         end
      default: begin
        tk = (m_cnt == INTERVAL - 1);
        if (tk && !a && m_pend == PMAX) m_ovf = 1;
        m_pend = next_pend(m_pend, tk, a);
        m_cnt = tk ? 0 : m_cnt + 1;
      end
    endcase
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string rt;
    rt = (m_phase == 0) ? "R2 req" : (m_phase == 1) ? "R4 req" : "R7 req";
    chk(ref_req === exp_req(), rt, ref_req, exp_req());
    chk(mem_ready === m_ready, "R5 ready", mem_ready, m_ready);
    chk(pend_overflow === m_ovf, "R8 overflow", pend_overflow, m_ovf);
  endtask

  task automatic step(input bit a);
    ref_ack = a;
    @(posedge clk);
    model_edge(a);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int gap;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ref_req && !mem_ready && !pend_overflow, "R1 reset outputs", {ref_req, mem_ready, pend_overflow}, 0);
    rst_n = 1'b1;

    // R2 / R3: start-up wait with random acknowledges that must be ignored
    for (int i = 0; i < STARTUP - 1; i++) step(($urandom % 4) == 0);
    chk(ref_req === 1'b0, "R2 low one edge before end", ref_req, 0);
    step(1'b1);
    chk(ref_req === 1'b1, "R2 high at end of wait", ref_req, 1);
    chk(mem_ready === 1'b0, "R3 ack in wait not counted", mem_ready, 0);

    // R4 / R5: warm-up, random acknowledge spacing
    while (!m_ready) begin
      step(($urandom % 3) == 0);
      if (!m_ready) chk(ref_req && !mem_ready, "R4 warm-up held", {ref_req, mem_ready}, 2);
    end
    chk(mem_ready === 1'b1, "R5 ready after eighth ack", mem_ready, 1);

    // R6: first tick exactly one interval after ready
    gap = 0;
    while (!ref_req && gap < 2 * INTERVAL) begin step(1'b0); gap++; end
    chk(gap == INTERVAL, "R6 first interval", gap, INTERVAL);

    // R6 / R3: clear, send a stray ack at zero, measure next gap
    step(1'b1); gap = 1;
    step(1'b1); gap++;
    chk(ref_req === 1'b0, "R3 ack at zero ignored", ref_req, 0);
    while (!ref_req && gap < 2 * INTERVAL) begin step(1'b0); gap++; end
    chk(gap == INTERVAL, "R6 steady interval", gap, INTERVAL);

    // R7: random acknowledge traffic
    for (int i = 0; i < 20000; i++) step(($urandom % 600) == 0);

    // R8: starve the scheduler past saturation
    for (int i = 0; i < (PMAX + 3) * INTERVAL; i++) step(1'b0);
    chk(pend_overflow === 1'b1, "R8 overflow set", pend_overflow, 1);
    for (int i = 0; i < PMAX - 1; i++) step(1'b1);
    chk(ref_req === 1'b1, "R8 still owed before last ack", ref_req, 1);
    step(1'b1);
    chk(ref_req === 1'b0, "R8 cleared after PEND_MAX acks", ref_req, 0);
    chk(pend_overflow === 1'b1, "R8 overflow sticky", pend_overflow, 1);

    // R7: tick and ack on the same edge
    for (int i = 0; i < 3 * INTERVAL; i++) step(($urandom % 2) == 0);

    // R1 / R5: reset in the middle of the run phase
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    chk(!mem_ready && !pend_overflow && !ref_req, "R1 mid-run reset", {ref_req, mem_ready, pend_overflow}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) step(1'b1);
    chk(mem_ready === 1'b0, "R5 ready low after reset", mem_ready, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule